// File: doc/BRIEF.md
# Shifted Bitmask Field Unit

This unit builds a contiguous run of ones whose length and position are programmable, and applies it to a source word. The run is one longer than the length field, so a length field of zero selects a single bit and the largest value selects the whole word. The run is then placed at an offset taken from the low bits of a shift-amount word. The placed run is used to set, clear or flip a field of the source. In the extract modes the run masks a field that has been moved down to bit zero instead.

A reversed-extract mode takes bits from the opposite end of the word. When the offset register selector is zero, the offset defaults to the top bit position, and the mode becomes a plain bit reversal of the source, trimmed to the run length. The datapath width is a parameter and must be a power of two. The result is registered, so it appears one clock after the operands are presented. Opcode decode and register-file reads stay outside the block.

Top module: `bitmask_field_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_o` becomes all zeros, whatever the other inputs are.
- R2: The run of ones has `len_i`+1 bits starting at bit 0. A length of 0 gives a single bit, and a length of WIDTH-1 gives all ones with no overflow to zero.
- R3: The offset is the low log2(WIDTH) bits of `shamt_i`. All higher bits of `shamt_i` have no effect.
- R4: Code 0 (set) yields `src_i` OR (run shifted left by offset). Run bits shifted past the top are lost.
- R5: Code 1 (clear) yields `src_i` AND NOT (run shifted left by offset).
- R6: Code 2 (invert) yields `src_i` XOR (run shifted left by offset).
- R7: Code 3 (extract) yields run AND (`src_i` logically shifted right by offset). Zeros fill from the top.
- R8: Code 4 (reversed extract) with `off_zero_i` low uses base = offset. It bit-reverses `src_i`, shifts that right by (WIDTH-1-base) and ANDs the run, so bit i of the result is `src_i`[base-i] for i up to min(base, length).
- R9: Code 4 with `off_zero_i` high takes base = WIDTH-1 and ignores `shamt_i`. With length WIDTH-1 the result is the full bit reversal of `src_i`.
- R10: Codes 5, 6 and 7 yield all zeros.
- R11: `off_zero_i` has no effect on codes 0 to 3.
- R12: The result for operands presented before a rising edge appears on `result_o` after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | WIDTH | Source data word |
| shamt_i | input | WIDTH | Shift-amount word; only the low log2(WIDTH) bits are used |
| len_i | input | log2(WIDTH) | Run length minus one |
| op_i | input | 3 | Operation code: 0 set, 1 clear, 2 invert, 3 extract, 4 reversed extract |
| off_zero_i | input | 1 | High when the offset register selector is zero |
| result_o | output | WIDTH | Registered result |

## Verification
The bench builds the unit with its default WIDTH of 64, so the offset and length fields are six bits wide. This makes the extreme corners reachable: a 64-bit run, offsets of 63 that push most of the run off the top, and shift words whose upper 58 bits are set. Reversed extract is exercised both with a register offset and with the default top offset. A pseudo-random sweep mixes every code, including the unused ones, so each path is compared against an independent bit-by-bit model.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

    typedef enum logic [2:0] {
        BMF_SET  = 3'd0,
        BMF_CLR  = 3'd1,
        BMF_INV  = 3'd2,
        BMF_EXT  = 3'd3,
        BMF_REXT = 3'd4
    } bmf_op_e;

    typedef struct packed {
        logic do_set;
        logic do_clr;
        logic do_inv;
        logic do_ext;
        logic do_rext;
    } bmf_ctrl_t;

    function automatic bmf_ctrl_t bmf_decode(input logic [2:0] code);
        bmf_ctrl_t c;
        c = '0;
        case (code)
            BMF_SET:  c.do_set  = 1'b1;
            BMF_CLR:  c.do_clr  = 1'b1;
            BMF_INV:  c.do_inv  = 1'b1;
            BMF_EXT:  c.do_ext  = 1'b1;
            BMF_REXT: c.do_rext = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bmf_run_gen.sv
// Builds len+1 contiguous ones from bit 0 without overflowing at the top length.
module bmf_run_gen #(
    parameter int WIDTH = 64,
    parameter int LW    = $clog2(WIDTH)
) (
    input  logic [LW-1:0]    len_i,
    output logic [WIDTH-1:0] run_o
);
    localparam logic [WIDTH-1:0] ONES = '1;

    logic [WIDTH-1:0] low_part;

    always_comb begin
        // low_part holds len ones; one more is appended at bit 0
        low_part = ~(ONES << len_i);
        run_o    = {low_part[WIDTH-2:0], 1'b1};
    end
endmodule

// File: rtl/bmf_field_path.sv
// Placement and extraction shifters, including the reversed-data path.
module bmf_field_path #(
    parameter int WIDTH = 64,
    parameter int LW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src_i,
    input  logic [LW-1:0]    off_i,
    input  logic             off_zero_i,
    input  logic [WIDTH-1:0] run_i,
    output logic [WIDTH-1:0] placed_o,
    output logic [WIDTH-1:0] ext_o,
    output logic [WIDTH-1:0] rext_o
);
    logic [WIDTH-1:0] src_rev;
    logic [LW-1:0]    rev_base;
    logic [LW-1:0]    rev_shift;

    for (genvar g = 0; g < WIDTH; g++) begin : g_rev
        assign src_rev[g] = src_i[WIDTH-1-g];
    end

    always_comb begin
        rev_base  = off_zero_i ? {LW{1'b1}} : off_i;
        // WIDTH is a power of two, so (WIDTH-1) - base is the complement
        rev_shift = ~rev_base;
        placed_o  = run_i << off_i;
        ext_o     = run_i & (src_i >> off_i);
        rext_o    = run_i & (src_rev >> rev_shift);
    end
endmodule

// File: rtl/bitmask_field_unit.sv
module bitmask_field_unit #(
    parameter int WIDTH = 64,
    parameter int LW    = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] src_i,
    input  logic [WIDTH-1:0] shamt_i,
    input  logic [LW-1:0]    len_i,
    input  logic [2:0]       op_i,
    input  logic             off_zero_i,
    output logic [WIDTH-1:0] result_o
);
    import bmf_pkg::*;

    bmf_ctrl_t        ctrl;
    logic [LW-1:0]    offset;
    logic [WIDTH-1:0] run;
    logic [WIDTH-1:0] placed;
    logic [WIDTH-1:0] ext_val;
    logic [WIDTH-1:0] rext_val;
    logic [WIDTH-1:0] next_val;
    logic [WIDTH-1:0] result_q;

    assign ctrl   = bmf_decode(op_i);
    assign offset = shamt_i[LW-1:0];

    bmf_run_gen #(.WIDTH(WIDTH), .LW(LW)) run_gen_i (
        .len_i (len_i),
        .run_o (run)
    );

    bmf_field_path #(.WIDTH(WIDTH), .LW(LW)) path_i (
        .src_i      (src_i),
        .off_i      (offset),
        .off_zero_i (off_zero_i),
        .run_i      (run),
        .placed_o   (placed),
        .ext_o      (ext_val),
        .rext_o     (rext_val)
    );

    always_comb begin
        next_val = '0;
        if (ctrl.do_set)       next_val = src_i | placed;
        else if (ctrl.do_clr)  next_val = src_i & ~placed;
        else if (ctrl.do_inv)  next_val = src_i ^ placed;
        else if (ctrl.do_ext)  next_val = ext_val;
        else if (ctrl.do_rext) next_val = rext_val;
    end

    always_ff @(posedge clk) begin
        if (rst) result_q <= '0;
        else     result_q <= next_val;
    end

    assign result_o = result_q;
endmodule

// File: rtl/bmf_checker.sv
module bmf_checker #(
    parameter int WIDTH = 64,
    parameter int LW    = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] src_i,
    input logic [WIDTH-1:0] shamt_i,
    input logic [LW-1:0]    len_i,
    input logic [2:0]       op_i,
    input logic             off_zero_i,
    input logic [WIDTH-1:0] result_o
);
    function automatic logic [WIDTH-1:0] flip(input logic [WIDTH-1:0] v);
        logic [WIDTH-1:0] r;
        for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
        return r;
    endfunction

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        $past(rst) |-> result_o == '0);

    // R10
    unused_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i > 3'd4) |=> result_o == '0);

    // R4
    set_keeps_src_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0) |=> (result_o & $past(src_i)) == $past(src_i));

    // R5
    clr_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd1) |=> (result_o & ~$past(src_i)) == '0);

    // R6
    inv_changes_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd2) |=> result_o != $past(src_i));

    // R2
    single_bit_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd3 && len_i == '0) |=> result_o[WIDTH-1:1] == '0);

    // R9
    full_rev_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd4 && off_zero_i && len_i == {LW{1'b1}})
        |=> result_o == flip($past(src_i)));

    logic unused_ok;
    assign unused_ok = ^shamt_i;
endmodule

bind bitmask_field_unit bmf_checker #(.WIDTH(WIDTH), .LW(LW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .src_i      (src_i),
    .shamt_i    (shamt_i),
    .len_i      (len_i),
    .op_i       (op_i),
    .off_zero_i (off_zero_i),
    .result_o   (result_o)
);

// File: tb/bitmask_field_unit_tb_top.sv
`timescale 1ns/1ps
module bitmask_field_unit_tb_top;
    localparam int W  = 64;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  src = '0;
    logic [W-1:0]  shamt = '0;
    logic [LW-1:0] len = '0;
    logic [2:0]    op = 3'd0;
    logic          ozero = 1'b0;
    logic [W-1:0]  result;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } sb_item_t;

    sb_item_t     exp_q[$];
    logic [W-1:0] last_exp = '0;

    always #2 clk = ~clk;

    bitmask_field_unit #(.WIDTH(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src),
        .shamt_i    (shamt),
        .len_i      (len),
        .op_i       (op),
        .off_zero_i (ozero),
        .result_o   (result)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [W-1:0] sh,
                                           input logic [LW-1:0] ln, input logic [2:0] code,
                                           input logic z);
        logic [W-1:0] run, placed, r;
        int off, base, roff;
        off = int'(sh[LW-1:0]);
        for (int i = 0; i < W; i++) run[i] = (i <= int'(ln));
        for (int i = 0; i < W; i++) placed[i] = (i >= off) ? run[i-off] : 1'b0;
        r = '0;
        case (code)
            3'd0: r = s | placed;
            3'd1: r = s & ~placed;
            3'd2: r = s ^ placed;
            3'd3: for (int i = 0; i < W; i++) r[i] = (i + off < W) ? (s[i+off] & run[i]) : 1'b0;
            3'd4: begin
                base = z ? W - 1 : off;
                roff = W - 1 - base;
                for (int i = 0; i < W; i++)
                    r[i] = (i + roff < W) ? (run[i] & s[W-1-(i+roff)]) : 1'b0;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present operands at the falling edge and queue the expected result.
    task automatic drive(input logic [W-1:0] s, input logic [W-1:0] sh, input logic [LW-1:0] ln,
                         input logic [2:0] code, input logic z, input string tag);
        sb_item_t it;
        @(negedge clk);
        src = s; shamt = sh; len = ln; op = code; ozero = z;
        it.exp = model(s, sh, ln, code, z);
        it.tag = tag;
        exp_q.push_back(it);
        #1;
        // R12: new operands must not show before the next rising edge
        check(result, last_exp, "R12");
        last_exp = it.exp;
    endtask

    // Monitor: one result per rising edge, compared just after it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                sb_item_t it;
                it = exp_q.pop_front();
                check(result, it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lfsr_a;
        logic [W-1:0] lfsr_b;
        // R1: reset dominates live operands
        src = 64'hFFFF_0000_FFFF_0000; op = 3'd0; len = 6'd63;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(result, '0, "R1");
        rst = 1'b0;
        op = 3'd5;
        @(posedge clk);

        // R2: run length corners via extract at offset 0
        drive('1, 64'd0, 6'd0,  3'd3, 1'b0, "R2");
        drive('1, 64'd0, 6'd63, 3'd3, 1'b0, "R2");
        drive('1, 64'd0, 6'd7,  3'd3, 1'b0, "R2");
        // R3: high bits of the shift word ignored
        drive('0, 64'hFFFF_FFFF_FFFF_FFC4, 6'd3, 3'd0, 1'b0, "R3");
        drive(64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0048, 6'd15, 3'd3, 1'b0, "R3");
        // R4: set, including run pushed off the top
        drive(64'h0F00_0000_0000_0000, 64'd60, 6'd7, 3'd0, 1'b0, "R4");
        drive(64'h0000_0000_0000_0001, 64'd63, 6'd63, 3'd0, 1'b0, "R4");
        // R5: clear
        drive('1, 64'd8, 6'd15, 3'd1, 1'b0, "R5");
        // R6: invert the whole word
        drive(64'hAAAA_AAAA_AAAA_AAAA, 64'd0, 6'd63, 3'd2, 1'b0, "R6");
        drive(64'h1234_0000_0000_5678, 64'd30, 6'd9, 3'd2, 1'b0, "R6");
        // R7: logical right shift, zero fill
        drive(64'h8000_0000_0000_0000, 64'd63, 6'd63, 3'd3, 1'b0, "R7");
        drive(64'hDEAD_BEEF_1234_5678, 64'd16, 6'd11, 3'd3, 1'b0, "R7");
        // R8: reversed extract from register offset
        drive(64'h1A00_0000_0000_0000, 64'd60, 6'd3, 3'd4, 1'b0, "R8");
        drive(64'h0000_0000_0000_00B5, 64'd7, 6'd63, 3'd4, 1'b0, "R8");
        // R9: default top offset, full and partial reversal
        drive(64'h0123_4567_89AB_CDEF, 64'd5, 6'd63, 3'd4, 1'b1, "R9");
        drive(64'hC3F0_0000_0000_0001, 64'd33, 6'd7, 3'd4, 1'b1, "R9");
        // R10: unused codes
        drive('1, 64'd3, 6'd63, 3'd5, 1'b0, "R10");
        drive('1, 64'd0, 6'd10, 3'd6, 1'b1, "R10");
        drive(64'h5555_5555_5555_5555, 64'd1, 6'd1, 3'd7, 1'b0, "R10");
        // R11: selector flag has no effect outside reversed extract
        drive('0, 64'd12, 6'd4, 3'd0, 1'b1, "R11");
        drive(64'hFEDC_BA98_7654_3210, 64'd20, 6'd11, 3'd3, 1'b1, "R11");
        drive('1, 64'd40, 6'd3, 3'd1, 1'b1, "R11");

        // Mixed sweep across all codes (R4 R5 R6 R7 R8 R9 R10)
        lfsr_a = 64'h9E37_79B9_7F4A_7C15;
        lfsr_b = 64'hC2B2_AE3D_27D4_EB4F;
        for (int n = 0; n < 60; n++) begin
            lfsr_a = lfsr_a ^ (lfsr_a << 13);
            lfsr_a = lfsr_a ^ (lfsr_a >> 7);
            lfsr_a = lfsr_a ^ (lfsr_a << 17);
            lfsr_b = lfsr_b ^ (lfsr_b << 5) ^ lfsr_a;
            drive(lfsr_a, lfsr_b, lfsr_b[13:8], lfsr_b[18:16], lfsr_b[20], "R4_R10_sweep");
        end

        @(negedge clk);
        op = 3'd5;
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule